// File: doc/BRIEF.md
# Signature Reuse Predictor

This block learns, for each fill signature, whether cache lines inserted under that signature tend to be referenced again. It then turns that history into a 2-bit insertion priority for new fills. The predictor keeps one saturating counter per table entry. The table index is the signature with the prefetch flag appended as bit 0, so prefetch fills and demand fills under the same signature learn in separate halves of the table.

The replacement engine sends training events on two independent channels:
- A hit event fires on the first reuse of a line and increments the line's counter.
- An eviction event fires when a line leaves the cache without ever being reused and decrements the line's counter.

Each event carries the line's reuse bit. An event whose reuse bit is already set does not train.

A prediction request carries a signature, a prefetch flag and a writeback flag. One cycle later the block returns the insertion state:
- 0 (immediate) for a saturated counter.
- 2 (far) for a counter between the limits.
- 3 (distant) for a zero counter or any writeback.

All counters reset to 1, so a signature that has never been seen is not treated as a scan. The table depth is set by the signature width parameter. The default is reduced for simulation, and a signature width of 13 gives 16K counters.

Top module: `sig_hit_pred`

## Requirements
- R1: The table entry used is {signature, prefetch flag}, with the flag in bit 0. Training a prefetch entry leaves the demand entry of the same signature unchanged, and the reverse also holds.
- R2: After reset `pred_valid_o` is 0 and every counter holds 1, so an untrained non-writeback request predicts state 2.
- R3: A hit event with reuse bit 0 increments the addressed counter, which saturates at 7.
- R4: A hit event with reuse bit 1 changes no counter.
- R5: An eviction event with reuse bit 0 decrements the addressed counter, which saturates at 0. An eviction event with reuse bit 1 changes no counter.
- R6: A non-writeback prediction maps the counter to a state: 7 gives 0, 1 to 6 gives 2, and 0 gives 3.
- R7: A request with the writeback flag set predicts state 3 whatever the counter holds.
- R8: `pred_valid_o` is high exactly one cycle after each cycle in which `pred_valid_i` is high, and low otherwise. `pred_state_o` is valid whenever `pred_valid_o` is high.
- R9: A prediction issued in the same cycle as a training event to the same entry uses the counter value from before that update.
- R10: A hit and an eviction that address the same entry in the same cycle are both applied, the increment first and the decrement second. A counter at 7 therefore ends at 6, and a counter at 0 ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_valid_i | input | 1 | Prediction request |
| pred_sig_i | input | SIG_W | Signature of the fill being predicted |
| pred_pf_i | input | 1 | The fill is a prefetch |
| pred_wb_i | input | 1 | The fill is a writeback |
| pred_valid_o | output | 1 | Prediction result valid |
| pred_state_o | output | 2 | Insertion state (0 immediate, 2 far, 3 distant) |
| hit_valid_i | input | 1 | Hit training event |
| hit_sig_i | input | SIG_W | Insertion signature of the hit line |
| hit_pf_i | input | 1 | Prefetch flag stored with the hit line |
| hit_reused_i | input | 1 | Reuse bit of the hit line before this hit |
| evict_valid_i | input | 1 | Eviction training event |
| evict_sig_i | input | SIG_W | Insertion signature of the evicted line |
| evict_pf_i | input | 1 | Prefetch flag stored with the evicted line |
| evict_reused_i | input | 1 | Reuse bit of the evicted line |

## Verification
The assertions check every cycle that each counter holds when no event addresses it. They also check that counters stay at their limits under a lone increment or a lone decrement, and that a combined event on a full counter leaves 6. On the port side they check that valid follows each request with exactly one cycle of latency, and that a writeback request always yields state 3. The bench scenarios show the behaviours that depend on a history of training. These are the separation of the prefetch and demand halves, the old value seen by a read that meets a same-entry write, the mapping of each counter range to a state, and long mixed event streams checked against a counter model.

// File: rtl/sig_pred_pkg.sv
package sig_pred_pkg;
  typedef enum logic [1:0] {
    INS_IMM  = 2'd0,
    INS_MID  = 2'd1,
    INS_FAR  = 2'd2,
    INS_DIST = 2'd3
  } ins_state_e;
endpackage

// File: rtl/sig_pred_cell.sv
module sig_pred_cell #(
  parameter int CTR_W   = 3,
  parameter int RST_VAL = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CTR_W-1:0] ctr_o
);
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_ZERO = '0;
  localparam logic [CTR_W-1:0] CTR_RST  = CTR_W'(RST_VAL);

  logic [CTR_W-1:0] ctr_q, after_inc, after_dec;

  // increment first, then decrement (R10)
  always_comb begin
    after_inc = ctr_q;
    if (inc_i && ctr_q != CTR_MAX) after_inc = ctr_q + 1'b1;
    after_dec = after_inc;
    if (dec_i && after_inc != CTR_ZERO) after_dec = after_inc - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctr_q <= CTR_RST;
    else         ctr_q <= after_dec;
  end

  assign ctr_o = ctr_q;

  a_r4_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !dec_i) |=> $stable(ctr_q));
  a_r3_sat_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && ctr_q == CTR_MAX) |=> ctr_q == CTR_MAX);
  a_r5_sat_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && ctr_q == CTR_ZERO) |=> ctr_q == CTR_ZERO);
  a_r10_inc_then_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && dec_i && ctr_q == CTR_MAX) |=> ctr_q == CTR_MAX - 1'b1);
endmodule

// File: rtl/sig_pred_table.sv
module sig_pred_table #(
  parameter int IDX_W   = 10,
  parameter int CTR_W   = 3,
  parameter int RST_VAL = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_en_i,
  input  logic [IDX_W-1:0] inc_idx_i,
  input  logic             dec_en_i,
  input  logic [IDX_W-1:0] dec_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CTR_W-1:0] rd_ctr_o
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [CTR_W-1:0] ctr_arr [DEPTH];
  logic [DEPTH-1:0] inc_vec, dec_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign inc_vec[g] = inc_en_i && (inc_idx_i == IDX_W'(g));
    assign dec_vec[g] = dec_en_i && (dec_idx_i == IDX_W'(g));
    sig_pred_cell #(
      .CTR_W  (CTR_W),
      .RST_VAL(RST_VAL)
    ) i_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (inc_vec[g]),
      .dec_i (dec_vec[g]),
      .ctr_o (ctr_arr[g])
    );
  end

  // combinational read of registered state: same-cycle write is not visible (R9)
  assign rd_ctr_o = ctr_arr[rd_idx_i];

  a_r1_single_inc_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(inc_vec) && (inc_en_i == ($countones(inc_vec) == 1)));
endmodule

// File: rtl/sig_pred_map.sv
module sig_pred_map
  import sig_pred_pkg::*;
#(
  parameter int CTR_W = 3
) (
  input  logic [CTR_W-1:0] ctr_i,
  input  logic             wb_i,
  output ins_state_e       state_o
);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  always_comb begin
    if (wb_i || ctr_i == '0) state_o = INS_DIST;
    else if (ctr_i == CTR_MAX) state_o = INS_IMM;
    else state_o = INS_FAR;
  end
endmodule

// File: rtl/sig_hit_pred.sv
module sig_hit_pred
  import sig_pred_pkg::*;
#(
  parameter int SIG_W   = 9,
  parameter int CTR_W   = 3,
  parameter int RST_VAL = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pred_valid_i,
  input  logic [SIG_W-1:0] pred_sig_i,
  input  logic             pred_pf_i,
  input  logic             pred_wb_i,
  output logic             pred_valid_o,
  output logic [1:0]       pred_state_o,
  input  logic             hit_valid_i,
  input  logic [SIG_W-1:0] hit_sig_i,
  input  logic             hit_pf_i,
  input  logic             hit_reused_i,
  input  logic             evict_valid_i,
  input  logic [SIG_W-1:0] evict_sig_i,
  input  logic             evict_pf_i,
  input  logic             evict_reused_i
);
  localparam int IDX_W = SIG_W + 1;

  logic [IDX_W-1:0] rd_idx, inc_idx, dec_idx;
  logic             inc_en, dec_en;
  logic [CTR_W-1:0] rd_ctr;
  ins_state_e       state_d, state_q;
  logic             valid_q;

  // prefetch flag in bit 0 splits the table (R1)
  assign rd_idx  = {pred_sig_i, pred_pf_i};
  assign inc_idx = {hit_sig_i, hit_pf_i};
  assign dec_idx = {evict_sig_i, evict_pf_i};
  assign inc_en  = hit_valid_i && !hit_reused_i;
  assign dec_en  = evict_valid_i && !evict_reused_i;

  sig_pred_table #(
    .IDX_W  (IDX_W),
    .CTR_W  (CTR_W),
    .RST_VAL(RST_VAL)
  ) i_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_en_i (inc_en),
    .inc_idx_i(inc_idx),
    .dec_en_i (dec_en),
    .dec_idx_i(dec_idx),
    .rd_idx_i (rd_idx),
    .rd_ctr_o (rd_ctr)
  );

  sig_pred_map #(.CTR_W(CTR_W)) i_map (
    .ctr_i  (rd_ctr),
    .wb_i   (pred_wb_i),
    .state_o(state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      state_q <= INS_FAR;
    end else begin
      valid_q <= pred_valid_i;
      if (pred_valid_i) state_q <= state_d;
    end
  end

  assign pred_valid_o = valid_q;
  assign pred_state_o = state_q;

  a_r8_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_i |=> pred_valid_o);
  a_r8_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_valid_i |=> !pred_valid_o);
  a_r7_wb_distant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_valid_i && pred_wb_i) |=> pred_state_o == 2'd3);
  a_r6_no_mid_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> pred_state_o != 2'd1);
endmodule

// File: tb/test_sig_hit_pred.sv
module test_sig_hit_pred;
  localparam int SIG_W = 9;
  localparam int DEPTH = 2 ** (SIG_W + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic pv = 0, ppf = 0, pwb = 0, hv = 0, hpf = 0, hre = 0, ev = 0, epf = 0, ere = 0;
  logic [SIG_W-1:0] psig = '0, hsig = '0, esig = '0;
  logic pred_valid_o;
  logic [1:0] pred_state_o;

  sig_hit_pred #(.SIG_W(SIG_W)) i_sig_hit_pred (
    .clk_i(clk), .rst_ni(rst_n),
    .pred_valid_i(pv), .pred_sig_i(psig), .pred_pf_i(ppf), .pred_wb_i(pwb),
    .pred_valid_o(pred_valid_o), .pred_state_o(pred_state_o),
    .hit_valid_i(hv), .hit_sig_i(hsig), .hit_pf_i(hpf), .hit_reused_i(hre),
    .evict_valid_i(ev), .evict_sig_i(esig), .evict_pf_i(epf), .evict_reused_i(ere)
  );

  typedef struct { logic [1:0] st; string tag; } exp_t;
  exp_t q[$];
  int model[DEPTH];
  int checks = 0, errors = 0;

  function automatic logic [1:0] exp_state(int c, bit wb);
    if (wb || c == 0) return 2'd3;
    if (c == 7) return 2'd0;
    return 2'd2;
  endfunction

  task automatic cyc(bit a_pv, int a_ps, bit a_ppf, bit a_pwb,
                     bit a_hv, int a_hs, bit a_hpf, bit a_hre,
                     bit a_ev, int a_es, bit a_epf, bit a_ere, string tag);
    exp_t e;
    @(posedge clk); #1;
    pv = a_pv; psig = SIG_W'(a_ps); ppf = a_ppf; pwb = a_pwb;
    hv = a_hv; hsig = SIG_W'(a_hs); hpf = a_hpf; hre = a_hre;
    ev = a_ev; esig = SIG_W'(a_es); epf = a_epf; ere = a_ere;
    if (a_pv) begin
      e.st = exp_state(model[a_ps * 2 + int'(a_ppf)], a_pwb);
      e.tag = tag;
      q.push_back(e);
    end
    if (a_hv && !a_hre && model[a_hs * 2 + int'(a_hpf)] < 7) model[a_hs * 2 + int'(a_hpf)]++;
    if (a_ev && !a_ere && model[a_es * 2 + int'(a_epf)] > 0) model[a_es * 2 + int'(a_epf)]--;
  endtask

  task automatic pred(int s, bit pf, bit wb, string tag);
    cyc(1, s, pf, wb, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic hit(int s, bit pf, bit re);
    cyc(0, 0, 0, 0, 1, s, pf, re, 0, 0, 0, 0, "");
  endtask
  task automatic evict(int s, bit pf, bit re);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, s, pf, re, "");
  endtask
  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && pred_valid_o) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R8: unexpected valid, act=1 exp=0");
      end else begin
        e = q.pop_front();
        if (pred_state_o !== e.st) begin
          errors++;
          $display("FAIL %s: state act=%0d exp=%0d", e.tag, pred_state_o, e.st);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (pred_valid_o !== 1'b0) begin
      errors++; $display("FAIL R2: valid after reset act=%0b exp=0", pred_valid_o);
    end
    rst_n = 1'b1;
    pred(5, 0, 0, "R2");
    pred(300, 1, 0, "R2");
    // R3: train demand sig 5 up to saturation
    repeat (6) hit(5, 0, 0);
    pred(5, 0, 0, "R3/R6 ctr7");
    hit(5, 0, 0);
    pred(5, 0, 0, "R3 sat");
    // R1: prefetch half untouched
    pred(5, 1, 0, "R1 pf half");
    // R7: writeback forced distant
    pred(5, 0, 1, "R7 wb");
    // R4: reused hits do not train
    repeat (8) hit(6, 1, 1);
    pred(6, 1, 0, "R4");
    // R1 reverse: train pf half down, demand stays
    evict(20, 1, 0);
    pred(20, 1, 0, "R1/R5 pf 0");
    pred(20, 0, 0, "R1 demand");
    // R5: evictions
    evict(7, 0, 0);
    pred(7, 0, 0, "R5/R6 ctr0");
    evict(7, 0, 0);
    pred(7, 0, 0, "R5 floor");
    evict(8, 0, 1);
    pred(8, 0, 0, "R5 reused ignored");
    // R6: middle counters
    repeat (3) hit(9, 0, 0);
    pred(9, 0, 0, "R6 ctr4");
    // R9: counter at 6, hit and predict same entry same cycle
    repeat (5) hit(10, 0, 0);
    cyc(1, 10, 0, 0, 1, 10, 0, 0, 0, 0, 0, 0, "R9 pre-update");
    pred(10, 0, 0, "R9 after");
    // R9: decrement case, ctr 1 -> 0
    cyc(1, 11, 0, 0, 0, 0, 0, 0, 1, 11, 0, 0, "R9 pre-dec");
    pred(11, 0, 0, "R9 after dec");
    // R10: simultaneous inc and dec same entry
    cyc(0, 0, 0, 0, 1, 5, 0, 0, 1, 5, 0, 0, "");
    pred(5, 0, 0, "R10 7->6");
    cyc(0, 0, 0, 0, 1, 7, 0, 0, 1, 7, 0, 0, "");
    pred(7, 0, 0, "R10 0->0");
    cyc(0, 0, 0, 0, 1, 12, 0, 0, 1, 13, 0, 0, "");
    pred(12, 0, 0, "R10 diff inc");
    pred(13, 0, 0, "R10 diff dec");
    // R8: back-to-back then gap
    pred(5, 0, 0, "R8 b2b");
    pred(9, 0, 0, "R8 b2b");
    idle(); idle();
    // mixed stream against model
    for (int i = 0; i < 400; i++) begin
      cyc($urandom_range(0, 1) == 1, int'($urandom_range(0, 3)), $urandom_range(0, 1) == 1,
          $urandom_range(0, 7) == 0,
          $urandom_range(0, 1) == 1, int'($urandom_range(0, 3)), $urandom_range(0, 1) == 1,
          $urandom_range(0, 3) == 0,
          $urandom_range(0, 2) == 0, int'($urandom_range(0, 3)), $urandom_range(0, 1) == 1,
          $urandom_range(0, 3) == 0, "R3/R5/R10 mixed");
    end
    idle(); idle(); idle();
    checks++;
    if (q.size() != 0) begin
      errors++; $display("FAIL R8: missing results act=%0d exp=0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule